// File: doc/BRIEF.md
# Spectrum Bin Log-Power Converter

This block turns a stream of complex fixed-point transform bins into a stream of log-scaled power values for spectrum display. Each accepted bin carries a signed real and a signed imaginary part. The block squares and sums the two parts at full precision. It takes the base-2 logarithm from the position of the leading one plus a short fractional table, then scales the result to decibels. Bins come out in the order they went in, one output per input, with no reordering and no buffering.

The pipeline has a fixed depth of five registers. Valid and the end-of-frame flag travel through a matching delay line, so a 1024-bin frame comes out with its last flag on the output that belongs to input bin 1023. Gaps in the input stream appear as the same gaps at the output. A bin of zero power maps to the lowest output code, so the output is always defined.

Top module: `bin_db_conv`

## Requirements
- R1: While reset is low, and on every cycle after its release until the first accepted bin has travelled five cycles, `out_valid` and `out_last` are low.
- R2: A bin accepted when `in_valid` is high at a rising edge produces exactly one output with `out_valid` high five rising edges later. A cycle with `in_valid` low produces a cycle with `out_valid` low five edges later, so back-to-back bins and bubbles keep their spacing.
- R3: `out_last` equals the `in_last` of the bin that produced the output. It is never high while `out_valid` is low, and `in_last` is ignored on cycles where `in_valid` is low.
- R4: Power is P = re*re + im*im, where `in_re` and `in_im` are 16-bit two's complement. P is kept as a 33-bit unsigned value with no saturation, so the extreme (-32768, -32768) gives P = 2^31.
- R5: For P > 0, the base-2 logarithm is L = k*256 + T[m], where k is the bit index of the leading one of P and m is the three bits just below that leading one (zero-filled below bit 0). The table T is indexed by m = 0..7 and holds 0, 44, 82, 118, 150, 179, 207, 232.
- R6: `out_db` = floor(L * 12330 / 65536). This is 3.0103*L/256 in unsigned fixed point with 4 fractional bits (tenths of a decibel times 1.6). For example, P = 1 gives 0 and P = 2 gives 48.
- R7: An input of re = 0 and im = 0 produces `out_db` = 0, the lowest code.
- R8: Over bins of strictly increasing power, `out_db` never decreases, so bins of large amplitude give the largest outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input bin present this cycle |
| in_last | input | 1 | Input bin is the final bin of its frame |
| in_re | input | 16 | Real part, two's complement |
| in_im | input | 16 | Imaginary part, two's complement |
| out_valid | output | 1 | Output value present this cycle |
| out_last | output | 1 | Output belongs to the final bin of a frame |
| out_db | output | 12 | Log power, unsigned, 4 fractional bits |

## Verification
A wrong value in the squaring, normalising or scaling registers shows up as a wrong `out_db` on the output cycle of that bin, exactly five cycles after the bin enters. The bench compares every output against a model built from R4 to R6. A corrupted valid or last delay bit shows up as an output one cycle early or late, or as a missing or extra pulse. Such a fault also moves the frame marker away from bin 1023, so it is seen within the same five-cycle window. Stuck table entries or a wrong leading-one index are caught by the corner bins, the ascending-power sweep and a full 1024-bin frame with varied amplitudes.

// File: rtl/bdc_pkg.sv
// Package: shared constants and the fractional log table for the
// bin-to-dB converter. Assumes a 3-bit mantissa index and 8 fractional
// bits in the base-2 logarithm.
package bdc_pkg;

    localparam int MANT_BITS = 3;       // mantissa bits that index the table
    localparam int LOG_FB    = 8;       // fractional bits of log2 result
    localparam int DB_K      = 12330;   // round(3.0103 * 2^16 * 16 / 256)
    localparam int DB_SHIFT  = 16;      // right shift after the scale multiply
    localparam int LATENCY   = 5;       // register stages from input to output

    // round(256 * log2(1 + m/8)) for the mantissa index m
    function automatic logic [LOG_FB-1:0] frac_lut(input logic [MANT_BITS-1:0] m);
        logic [LOG_FB-1:0] v;
        case (m)
            3'd0:    v = 8'd0;
            3'd1:    v = 8'd44;
            3'd2:    v = 8'd82;
            3'd3:    v = 8'd118;
            3'd4:    v = 8'd150;
            3'd5:    v = 8'd179;
            3'd6:    v = 8'd207;
            default: v = 8'd232;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bdc_power.sv
// Module: bdc_power
// Squares both parts of a complex sample and sums them at full precision.
// Two register stages: products, then sum. Assumes two's complement inputs.
module bdc_power #(
    parameter int IN_W = 16,
    localparam int PRD_W = 2 * IN_W,
    localparam int PW    = 2 * IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  re,
    input  logic signed [IN_W-1:0]  im,
    output logic [PW-1:0]           pwr
);

    logic signed [PRD_W-1:0] re_x, im_x;
    logic [PRD_W-1:0]        sq_re, sq_im;

    assign re_x = PRD_W'(re);
    assign im_x = PRD_W'(im);

    // Stage 1: register the two squares
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_re <= '0;
            sq_im <= '0;
        end else begin
            sq_re <= $unsigned(re_x * re_x);
            sq_im <= $unsigned(im_x * im_x);
        end
    end

    // Stage 2: register their sum with one guard bit
    always_ff @(posedge clk) begin
        if (!rst_n) pwr <= '0;
        else        pwr <= {1'b0, sq_re} + {1'b0, sq_im};
    end

endmodule

// File: rtl/bdc_log2.sv
// Module: bdc_log2
// Base-2 logarithm of an unsigned power value in fixed point.
// Stage 3 finds the leading-one index and the mantissa bits below it;
// stage 4 appends the fractional table entry. A zero flag travels along.
module bdc_log2
    import bdc_pkg::*;
#(
    parameter int PW = 33,
    localparam int IDX_W = $clog2(PW),
    localparam int LQ_W  = IDX_W + LOG_FB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    pwr,
    output logic [LQ_W-1:0]  lq,
    output logic             zero
);

    logic [IDX_W-1:0]     k_c, k_q;
    logic [IDX_W-1:0]     sh_c;
    logic [MANT_BITS-1:0] mant_c, mant_q;
    logic                 zero_c, zero_q;

    // Leading-one search: highest set bit wins
    always_comb begin
        k_c = '0;
        for (int i = 0; i < PW; i++) begin
            if (pwr[i]) k_c = IDX_W'(i);
        end
    end

    assign zero_c = (pwr == '0);
    assign sh_c   = IDX_W'(PW - 1) - k_c;
    assign mant_c = MANT_BITS'((pwr << sh_c) >> (PW - 1 - MANT_BITS));

    // Stage 3: register index, mantissa and zero flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q    <= '0;
            mant_q <= '0;
            zero_q <= 1'b1;
        end else begin
            k_q    <= k_c;
            mant_q <= mant_c;
            zero_q <= zero_c;
        end
    end

    // Stage 4: assemble integer and fractional log parts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lq   <= '0;
            zero <= 1'b1;
        end else begin
            lq   <= {k_q, frac_lut(mant_q)};
            zero <= zero_q;
        end
    end

endmodule

// File: rtl/bdc_scale.sv
// Module: bdc_scale
// Multiplies the fixed-point log2 value by 10*log10(2) and truncates
// to the output format. A zero-power flag forces the lowest code.
module bdc_scale
    import bdc_pkg::*;
#(
    parameter int LQ_W  = 14,
    parameter int OUT_W = 12,
    localparam int PROD_W = LQ_W + 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LQ_W-1:0]   lq,
    input  logic              zero,
    output logic [OUT_W-1:0]  db
);

    logic [PROD_W-1:0] prod;

    assign prod = PROD_W'(lq) * PROD_W'(DB_K);

    // Stage 5: register the scaled value or the minimum code
    always_ff @(posedge clk) begin
        if (!rst_n)    db <= '0;
        else if (zero) db <= '0;
        else           db <= OUT_W'(prod >> DB_SHIFT);
    end

endmodule

// File: rtl/bin_db_conv.sv
// Module: bin_db_conv (top)
// Streams complex transform bins to log power in dB, one output per
// input, fixed latency of LATENCY cycles. Valid and last ride a delay
// line of the same depth, so frame markers stay aligned. No back-pressure.
module bin_db_conv
    import bdc_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    localparam int PW    = 2 * IN_W + 1,
    localparam int IDX_W = $clog2(PW),
    localparam int LQ_W  = IDX_W + LOG_FB
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_last,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    output logic                   out_valid,
    output logic                   out_last,
    output logic [OUT_W-1:0]       out_db
);

    logic [PW-1:0]   pwr;
    logic [LQ_W-1:0] lq;
    logic            zero;
    logic [LATENCY-1:0] v_sr, l_sr;

    bdc_power #(.IN_W(IN_W)) power_i (
        .clk(clk), .rst_n(rst_n), .re(in_re), .im(in_im), .pwr(pwr)
    );

    bdc_log2 #(.PW(PW)) log2_i (
        .clk(clk), .rst_n(rst_n), .pwr(pwr), .lq(lq), .zero(zero)
    );

    bdc_scale #(.LQ_W(LQ_W), .OUT_W(OUT_W)) scale_i (
        .clk(clk), .rst_n(rst_n), .lq(lq), .zero(zero), .db(out_db)
    );

    // Side-band delay line, one register per data stage
    genvar s;
    generate
        for (s = 0; s < LATENCY; s++) begin : g_side
            // Shift valid and qualified last forward by one stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_sr[s] <= 1'b0;
                    l_sr[s] <= 1'b0;
                end else if (s == 0) begin
                    v_sr[s] <= in_valid;
                    l_sr[s] <= in_valid & in_last;
                end else begin
                    v_sr[s] <= v_sr[(s == 0) ? 0 : s-1];
                    l_sr[s] <= l_sr[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign out_valid = v_sr[LATENCY-1];
    assign out_last  = l_sr[LATENCY-1];

endmodule

// File: rtl/bin_db_conv_chk.sv
// Module: bin_db_conv_chk
// Port-level checker for bin_db_conv, attached by bind. Properties that
// look five cycles back are armed only once five edges have passed
// since reset was released.
module bin_db_conv_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_last,
    input logic signed [IN_W-1:0] in_re,
    input logic signed [IN_W-1:0] in_im,
    input logic                   out_valid,
    input logic                   out_last,
    input logic [OUT_W-1:0]       out_db
);

    logic [2:0] since_rst;
    logic       armed;

    // Count edges since reset release, saturating at five
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
    end
    assign armed = (since_rst == 3'd5);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !out_valid && !out_last);                                   // R1
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> out_valid == $past(in_valid, 5));                            // R2
    AST_LAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> out_last == $past(in_valid && in_last, 5));                  // R3
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);                                               // R3
    AST_ZERO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(in_valid && in_re == 0 && in_im == 0, 5) |-> out_db == '0); // R7
    AST_LARGE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(in_valid && (in_re > 1 || in_re < -1), 5) |-> out_db != '0); // R8

endmodule

bind bin_db_conv bin_db_conv_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_last(out_last), .out_db(out_db)
);

// File: tb/bin_db_conv_tb_top.sv
// Bench: directed scenarios for bin_db_conv. A negedge monitor compares
// each output against a queue of expected values built from R4..R6.
module bin_db_conv_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;
    localparam int LAT        = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_last = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic               out_valid;
    logic               out_last;
    logic [11:0]        out_db;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int mono_prev = 0;

    int    q_db[$];
    bit    q_last[$];
    int    q_cyc[$];
    string q_tag[$];

    bin_db_conv dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
        .out_last(out_last), .out_db(out_db)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Model of R4..R7: power, leading-one log2 with table, scale
    function automatic int exp_db(input int re, input int im);
        int     tab [8] = '{0, 44, 82, 118, 150, 179, 207, 232};
        longint p, n, lq;
        int     k, m;
        p = longint'(re) * re + longint'(im) * im;
        if (p == 0) return 0;
        k = 0;
        for (int i = 0; i < 33; i++) if (p[i]) k = i;
        n = (p << (32 - k)) & 64'h1_FFFF_FFFF;
        m = int'((n >> 29) & 7);
        lq = longint'(k) * 256 + tab[m];
        return int'((lq * 12330) >> 16);
    endfunction

    task automatic send(input int re, input int im, input bit last, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_last = last;
        in_re = 16'(re); in_im = 16'(im);
        q_db.push_back(exp_db(re, im));
        q_last.push_back(last);
        q_cyc.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    // Bubble cycle: in_last toggled high to show it is ignored (R3)
    task automatic bubble();
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b1;
        in_re = 16'sh1234; in_im = 16'sh0F0F;
    endtask

    task automatic drain();
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        while (q_db.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // Output monitor: value (R4..R8), last (R3), timing (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_last && !out_valid) check(1'b0, "R3 last without valid", 1, 0);
            if (out_valid) begin
                if (q_db.size() == 0) begin
                    check(1'b0, "R2 unexpected output", 1, 0);
                end else begin
                    check(cyc == q_cyc[0] + LAT, "R2 latency", cyc - q_cyc[0], LAT);
                    check(int'(out_db) == q_db[0], q_tag[0], int'(out_db), q_db[0]);
                    check(out_last == q_last[0], "R3 last flag", out_last, q_last[0]);
                    if (q_tag[0] == "R8") begin
                        check(int'(out_db) >= mono_prev, "R8 monotonic", int'(out_db), mono_prev);
                        mono_prev = int'(out_db);
                    end
                    void'(q_db.pop_front()); void'(q_last.pop_front());
                    void'(q_cyc.pop_front()); void'(q_tag.pop_front());
                end
            end else if (q_db.size() != 0 && cyc >= q_cyc[0] + LAT) begin
                check(1'b0, "R2 missing output", 0, 1);
                void'(q_db.pop_front()); void'(q_last.pop_front());
                void'(q_cyc.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    // R1: outputs idle during reset and just after release
    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; in_last = 1'b1; in_re = 16'sd500; in_im = -16'sd300;
        repeat (4) begin
            @(negedge clk);
            check(!out_valid && !out_last, "R1 in reset", {out_valid, out_last}, 0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(!out_valid && !out_last, "R1 after release", {out_valid, out_last}, 0);
        end
    endtask

    // R4..R7 corner bins, sent back to back (R2)
    task automatic t_corners();
        send(0, 0, 1'b0, "R7 zero power");
        send(1, 0, 1'b0, "R6 unit power");
        send(0, -1, 1'b0, "R6 unit power neg");
        send(1, 1, 1'b0, "R6 power two");
        send(3, 4, 1'b0, "R5 power 25");
        send(255, 0, 1'b0, "R5 power 65025");
        send(-1000, 700, 1'b0, "R5 mixed sign");
        send(-32768, -32768, 1'b0, "R4 extreme");
        send(32767, -32768, 1'b1, "R4 near extreme");
        drain();
        check(exp_db(1, 1) == 48 && exp_db(-32768, -32768) == 1493,
              "R6 model anchors", exp_db(1, 1), 48);
    endtask

    // R2/R3 bubbles with in_last high while invalid
    task automatic t_bubbles();
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 1) bubble();
            send(i * 97 - 1500, 800 - i * 41, (i % 5) == 4, "R6 bubbled");
        end
        drain();
    endtask

    // R8 ascending power sweep
    task automatic t_monotonic();
        mono_prev = 0;
        for (int i = 0; i < 180; i++) send(i * 180, i * 3, 1'b0, "R8");
        drain();
    endtask

    // R3 full 1024-bin frame, strong centre, random gaps
    task automatic t_frame();
        for (int i = 0; i < 1024; i++) begin
            int a;
            if (($urandom % 4) == 0) bubble();
            a = (i >= 384 && i < 640) ? 12000 : 40;
            send(a + (i % 7), -(a / 2) + (i % 5), i == 1023, "R6 frame bin");
        end
        drain();
    endtask

    initial begin
        t_reset();
        t_corners();
        t_bubbles();
        t_monotonic();
        t_frame();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WD_CYCLES);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule